// File: doc/BRIEF.md
# Fetch-Counter Scan-Line Interrupt Timer

This block turns a loadable 7-bit opcode-fetch counter into a once-per-scan-line interrupt source and then plays out the acknowledge that follows. The counter advances by one for every fetch announced on `fetch_stb` and can be overwritten at any time with `load_stb`/`load_val`. When an advance carries bit 6 from 1 to 0, the 0x7F to 0x00 step, the block raises `irq`, provided `int_en` is high.

While `irq` is pending, the next fetch strobe is taken as the acknowledge. From that point a sequencer runs a stretched acknowledge of six clocks, two of which are wait states. It follows with a seven-clock restart that pushes the two return-address bytes. It then pulses `svc_start` in the clock in which the service routine's first fetch may begin. A free-running line clock restarts at every acknowledge, so the length of each line can be read at the ports.

The line splits into 6 acknowledge clocks, 7 restart clocks, 58 clocks of service code and 34 four-clock no-op fetches. That is 207 clocks, one clock short of a nominal 208-clock line. The sequencer has three states:
- RUN: fetches count.
- ACK: the stretched acknowledge.
- PUSH: the restart.

Its transitions are:
- TAKE (RUN to ACK): a fetch strobe arrives while a request is pending.
- WAITS_DONE (ACK to PUSH): after the sixth acknowledge clock.
- RESUME (PUSH to RUN): after the seventh restart clock.

Top module: `rlt_line_irq_timer`

## Requirements
- R1: While `rst_n` is low, `irq`, `ack_busy`, `ack_wait`, `push_wr`, `push_hi` and `svc_start` are 0, and `rcnt` and `line_clk` are 0.
- R2: In RUN, each clock with `fetch_stb` high and `load_stb` low makes `rcnt` one higher in the next clock, modulo 128 (0x7F is followed by 0x00).
- R3: `load_stb` high in any state writes `load_val` into `rcnt` for the next clock, taking priority over a fetch. A load never raises `irq`, even when it clears bit 6.
- R4: A fetch in RUN that takes `rcnt` from 0x7F to 0x00 with `int_en` high sets `irq` from the next clock. `irq` then stays high until the acknowledge begins.
- R5: In every clock that follows a clock with `int_en` low, `irq` is 0. A wrap seen while `int_en` is low is lost, and a pending request is withdrawn.
- R6: A fetch strobe in RUN while `irq` is high is taken as the acknowledge (TAKE), and that fetch also advances `rcnt`. In the next clock `irq` is 0. `ack_busy` is then high for exactly 6 clocks, counted as acknowledge clocks 1 to 6, and `ack_wait` is high in acknowledge clocks 2 and 3 only.
- R7: The restart occupies the 7 clocks after the acknowledge, clocks 7 to 13 counting the first acknowledge clock as 1. `push_wr` pulses in clocks 9 and 12, and `push_hi` is high only with the first pulse, which carries the high byte of the return address.
- R8: `svc_start` is a single-clock pulse in clock 14, the clock right after the restart, and the sequencer is back in RUN in that clock.
- R9: `fetch_stb` has no effect while the acknowledge or the restart is in progress: `rcnt` holds.
- R10: `line_clk` is 1 in the first acknowledge clock and rises by one per clock, saturating at its maximum. With the reload of 0x5D, one service fetch and 34 four-clock fetches, `line_clk` reads 207 in the clock whose fetch strobe starts the next acknowledge, one less than the nominal 208.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_stb | input | 1 | One clock per opcode fetch, given in the clock before the fetch |
| load_stb | input | 1 | Write `load_val` into the counter |
| load_val | input | 7 | Value to load |
| int_en | input | 1 | Maskable interrupt enable |
| irq | output | 1 | Pending line interrupt request |
| ack_busy | output | 1 | Stretched acknowledge in progress |
| ack_wait | output | 1 | Acknowledge wait-state clock |
| push_wr | output | 1 | Return-address byte write during restart |
| push_hi | output | 1 | The current push write is the high byte |
| svc_start | output | 1 | First service-routine fetch may begin |
| rcnt | output | 7 | Fetch counter value |
| line_clk | output | 9 | Clocks since the last acknowledge began, 1-based |

## Verification
A counter that is off by one step moves the wrap by a whole fetch, four clocks. It shows within one line as `irq` rising at the wrong clock and as a `line_clk` reading other than 207 at the next acknowledge. A sequencer phase that is off by one moves `ack_busy`, `ack_wait`, the `push_wr` pulses and `svc_start`. The error is visible in the very first line, within 14 clocks of the acknowledge. A request latch that ignores the enable or the acknowledge leaves `irq` wrong in the clock after the cause.

// File: rtl/rlt_pkg.sv
`timescale 1ns/1ps
package rlt_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_ACK  = 2'd1,
        ST_PUSH = 2'd2
    } seq_state_t;

    // Default cycle accounting of the acknowledge and restart
    localparam int unsigned DEF_ACK_CYC  = 6;
    localparam int unsigned DEF_PUSH_CYC = 7;

endpackage

// File: rtl/rlt_fetch_counter.sv
`timescale 1ns/1ps
module rlt_fetch_counter #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step_en,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    localparam int unsigned MSB = CNT_W - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

    // Wrap: an advance (not a load) carries the top bit from 1 to 0
    assign wrap = step_en && !load_stb && cnt_q[MSB] && !cnt_inc[MSB];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_stb) begin
            cnt_q <= load_val;
        end else if (step_en) begin
            cnt_q <= cnt_inc;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/rlt_req_latch.sv
`timescale 1ns/1ps
module rlt_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic int_en,
    input  logic wrap,
    input  logic take,
    output logic irq
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (!int_en) begin
            irq_q <= 1'b0;
        end else if (take) begin
            irq_q <= 1'b0;
        end else if (wrap) begin
            irq_q <= 1'b1;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/rlt_ack_seq.sv
`timescale 1ns/1ps
module rlt_ack_seq
    import rlt_pkg::*;
#(
    parameter int unsigned ACK_CYC    = DEF_ACK_CYC,
    parameter int unsigned PUSH_CYC   = DEF_PUSH_CYC,
    parameter int unsigned WAIT_FIRST = 2,
    parameter int unsigned WAIT_LAST  = 3,
    parameter int unsigned WR_HI_AT   = 3,
    parameter int unsigned WR_LO_AT   = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    output seq_state_t state,
    output logic       running,
    output logic       ack_busy,
    output logic       ack_wait,
    output logic       push_wr,
    output logic       push_hi,
    output logic       svc_start
);

    localparam int unsigned MAX_CYC = (ACK_CYC > PUSH_CYC) ? ACK_CYC : PUSH_CYC;
    localparam int unsigned PH_W    = $clog2(MAX_CYC + 1);
    localparam logic [PH_W-1:0] ACK_END   = PH_W'(ACK_CYC);
    localparam logic [PH_W-1:0] PUSH_END  = PH_W'(PUSH_CYC);
    localparam logic [PH_W-1:0] W_FIRST   = PH_W'(WAIT_FIRST);
    localparam logic [PH_W-1:0] W_LAST    = PH_W'(WAIT_LAST);
    localparam logic [PH_W-1:0] HI_AT     = PH_W'(WR_HI_AT);
    localparam logic [PH_W-1:0] LO_AT     = PH_W'(WR_LO_AT);
    localparam logic [PH_W-1:0] PH_ONE    = PH_W'(1);

    seq_state_t      state_q;
    seq_state_t      state_nxt;
    logic [PH_W-1:0] phase_q;
    logic            svc_q;

    // Transitions: TAKE, WAITS_DONE, RESUME
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_RUN:  if (take)               state_nxt = ST_ACK;
            ST_ACK:  if (phase_q == ACK_END)  state_nxt = ST_PUSH;
            ST_PUSH: if (phase_q == PUSH_END) state_nxt = ST_RUN;
            default:                          state_nxt = ST_RUN;
        endcase
    end

    // State register, phase within state and start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            phase_q <= '0;
            svc_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            if (state_nxt == ST_RUN) begin
                phase_q <= '0;
            end else if (state_nxt != state_q) begin
                phase_q <= PH_ONE;
            end else begin
                phase_q <= phase_q + PH_ONE;
            end
            svc_q <= (state_q == ST_PUSH) && (state_nxt == ST_RUN);
        end
    end

    // Outputs decoded from state and phase
    always_comb begin
        running  = 1'b0;
        ack_busy = 1'b0;
        ack_wait = 1'b0;
        push_wr  = 1'b0;
        push_hi  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                running = 1'b1;
            end
            ST_ACK: begin
                ack_busy = 1'b1;
                ack_wait = (phase_q >= W_FIRST) && (phase_q <= W_LAST);
            end
            ST_PUSH: begin
                push_wr = (phase_q == HI_AT) || (phase_q == LO_AT);
                push_hi = (phase_q == HI_AT);
            end
            default: begin
                running = 1'b0;
            end
        endcase
    end

    assign state     = state_q;
    assign svc_start = svc_q;

endmodule

// File: rtl/rlt_line_clock.sv
`timescale 1ns/1ps
module rlt_line_clock #(
    parameter int unsigned LC_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    output logic [LC_W-1:0] line_clk
);

    localparam logic [LC_W-1:0] LC_MAX = {LC_W{1'b1}};
    localparam logic [LC_W-1:0] LC_ONE = LC_W'(1);

    logic [LC_W-1:0] lc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lc_q <= '0;
        end else if (take) begin
            lc_q <= LC_ONE;
        end else if (lc_q != LC_MAX) begin
            lc_q <= lc_q + LC_ONE;
        end
    end

    assign line_clk = lc_q;

endmodule

// File: rtl/rlt_line_irq_timer.sv
`timescale 1ns/1ps
module rlt_line_irq_timer
    import rlt_pkg::*;
#(
    parameter int unsigned CNT_W    = 7,
    parameter int unsigned LC_W     = 9,
    parameter int unsigned ACK_CYC  = DEF_ACK_CYC,
    parameter int unsigned PUSH_CYC = DEF_PUSH_CYC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_stb,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             int_en,
    output logic             irq,
    output logic             ack_busy,
    output logic             ack_wait,
    output logic             push_wr,
    output logic             push_hi,
    output logic             svc_start,
    output logic [CNT_W-1:0] rcnt,
    output logic [LC_W-1:0]  line_clk
);

    seq_state_t state;
    logic       running;
    logic       step_en;
    logic       wrap;
    logic       take;

    assign step_en = running && fetch_stb;
    assign take    = step_en && irq;

    rlt_fetch_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (load_stb),
        .load_val (load_val),
        .step_en  (step_en),
        .cnt      (rcnt),
        .wrap     (wrap)
    );

    rlt_req_latch u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .int_en (int_en),
        .wrap   (wrap),
        .take   (take),
        .irq    (irq)
    );

    rlt_ack_seq #(
        .ACK_CYC  (ACK_CYC),
        .PUSH_CYC (PUSH_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .state     (state),
        .running   (running),
        .ack_busy  (ack_busy),
        .ack_wait  (ack_wait),
        .push_wr   (push_wr),
        .push_hi   (push_hi),
        .svc_start (svc_start)
    );

    rlt_line_clock #(.LC_W(LC_W)) u_lc (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .line_clk (line_clk)
    );

endmodule

// File: rtl/rlt_line_irq_timer_chk.sv
`timescale 1ns/1ps
module rlt_line_irq_timer_chk #(
    parameter int unsigned CNT_W   = 7,
    parameter int unsigned LC_W    = 9,
    parameter int unsigned ACK_CYC = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_stb,
    input logic             load_stb,
    input logic [CNT_W-1:0] load_val,
    input logic             int_en,
    input logic             irq,
    input logic             ack_busy,
    input logic             push_wr,
    input logic             svc_start,
    input logic             running,
    input logic [CNT_W-1:0] rcnt,
    input logic [LC_W-1:0]  line_clk
);

    logic [7:0] ack_run;
    logic [3:0] wr_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_run <= '0;
            wr_seen <= '0;
        end else begin
            ack_run <= ack_busy ? ack_run + 8'd1 : 8'd0;
            if (ack_busy)     wr_seen <= '0;
            else if (push_wr) wr_seen <= wr_seen + 4'd1;
        end
    end

    // R5
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |=> !irq);

    // R6
    ack_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && fetch_stb && irq) |=> (ack_busy && !irq));

    // R6
    ack_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_busy) |-> (ack_run == 8'(ACK_CYC)));

    // R3
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (rcnt == $past(load_val)));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && fetch_stb && !load_stb) |=> (rcnt == CNT_W'($past(rcnt) + 1'b1)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load_stb) |=> (rcnt == $past(rcnt)));

    // R8
    svc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_start |=> !svc_start);

    // R7
    push_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_start |-> (wr_seen == 4'd2));

    // R10
    line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_busy) |-> (line_clk == LC_W'(1)));

endmodule

bind rlt_line_irq_timer rlt_line_irq_timer_chk #(
    .CNT_W   (CNT_W),
    .LC_W    (LC_W),
    .ACK_CYC (ACK_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_stb (fetch_stb),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .int_en    (int_en),
    .irq       (irq),
    .ack_busy  (ack_busy),
    .push_wr   (push_wr),
    .svc_start (svc_start),
    .running   (running),
    .rcnt      (rcnt),
    .line_clk  (line_clk)
);

// File: tb/rlt_line_irq_timer_tb_top.sv
`timescale 1ns/1ps
module rlt_line_irq_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fetch_stb;
    logic       load_stb;
    logic [6:0] load_val;
    logic       int_en;
    logic       irq, ack_busy, ack_wait, push_wr, push_hi, svc_start;
    logic [6:0] rcnt;
    logic [8:0] line_clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rlt_line_irq_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_stb (fetch_stb),
        .load_stb  (load_stb),
        .load_val  (load_val),
        .int_en    (int_en),
        .irq       (irq),
        .ack_busy  (ack_busy),
        .ack_wait  (ack_wait),
        .push_wr   (push_wr),
        .push_hi   (push_hi),
        .svc_start (svc_start),
        .rcnt      (rcnt),
        .line_clk  (line_clk)
    );

    // Advance one clock; return 1 ns after the edge (sample/drive point)
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        fetch_stb = 1'b0;
        load_stb  = 1'b0;
        load_val  = 7'h00;
    endtask

    task automatic t_reset();
        idle_inputs();
        int_en = 1'b1;
        rst_n  = 1'b0;
        repeat (3) step();
        // R1
        chk(irq == 0,       "R1 irq",       irq, 0);
        chk(ack_busy == 0,  "R1 ack_busy",  ack_busy, 0);
        chk(ack_wait == 0,  "R1 ack_wait",  ack_wait, 0);
        chk(push_wr == 0,   "R1 push_wr",   push_wr, 0);
        chk(push_hi == 0,   "R1 push_hi",   push_hi, 0);
        chk(svc_start == 0, "R1 svc_start", svc_start, 0);
        chk(rcnt == 0,      "R1 rcnt",      rcnt, 0);
        chk(line_clk == 0,  "R1 line_clk",  line_clk, 0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_count_load();
        // R2: advances, wrap with interrupts masked
        int_en = 1'b0;
        load_stb = 1'b1; load_val = 7'h7D;
        step();
        load_stb = 1'b0;
        chk(rcnt == 7'h7D, "R3 load", rcnt, 7'h7D);
        fetch_stb = 1'b1;
        step(); chk(rcnt == 7'h7E, "R2 step", rcnt, 7'h7E);
        step(); chk(rcnt == 7'h7F, "R2 step", rcnt, 7'h7F);
        step(); chk(rcnt == 7'h00, "R2 wrap", rcnt, 0);
        fetch_stb = 1'b0;
        step();
        // R5: wrap while masked is lost
        chk(irq == 0, "R5 masked wrap", irq, 0);
        int_en = 1'b1;
        step(); step();
        chk(irq == 0, "R5 lost after unmask", irq, 0);
        // R3: load over a fetch, load clearing bit 6 raises nothing
        load_stb = 1'b1; load_val = 7'h7F;
        step();
        load_val = 7'h00; fetch_stb = 1'b1;
        step();
        load_stb = 1'b0; fetch_stb = 1'b0;
        chk(rcnt == 7'h00, "R3 load priority", rcnt, 0);
        step();
        chk(irq == 0, "R3 load no irq", irq, 0);
    endtask

    task automatic t_mask();
        int_en = 1'b1;
        load_stb = 1'b1; load_val = 7'h7F;
        step();
        load_stb = 1'b0; fetch_stb = 1'b1;
        step();
        fetch_stb = 1'b0;
        // R4
        chk(irq == 1, "R4 raise on wrap", irq, 1);
        step(); step(); step();
        chk(irq == 1, "R4 held pending", irq, 1);
        // R5
        int_en = 1'b0;
        step();
        chk(irq == 0, "R5 withdrawn", irq, 0);
        int_en = 1'b1;
        step();
        chk(irq == 0, "R5 stays clear", irq, 0);
    endtask

    task automatic t_lines(input int nlines);
        logic [6:0] exp_cnt;
        int_en = 1'b1;
        load_stb = 1'b1; load_val = 7'h7F;
        step();
        load_stb = 1'b0; fetch_stb = 1'b1;
        step();
        chk(irq == 1, "R4 pending before line", irq, 1);
        // this strobe is taken as the acknowledge
        step();
        exp_cnt = 7'h01;
        for (int ln = 0; ln < nlines; ln++) begin
            for (int n = 1; n <= 207; n++) begin
                bit busy;
                chk(ack_busy == (n <= 6),           "R6 ack_busy", ack_busy, int'(n <= 6));
                chk(ack_wait == (n == 2 || n == 3), "R6 ack_wait", ack_wait, int'(n == 2 || n == 3));
                chk(push_wr == (n == 9 || n == 12), "R7 push_wr",  push_wr, int'(n == 9 || n == 12));
                chk(push_hi == (n == 9),            "R7 push_hi",  push_hi, int'(n == 9));
                chk(svc_start == (n == 14),         "R8 svc_start", svc_start, int'(n == 14));
                chk(irq == (n >= 204),              "R4 irq in line", irq, int'(n >= 204));
                chk(rcnt == exp_cnt,                "R9 R2 rcnt", rcnt, exp_cnt);
                chk(line_clk == 9'(n),              "R10 line_clk", line_clk, n);
                if (n == 207)
                    chk(line_clk == 9'd207, "R10 period one short of 208", line_clk, 207);
                // stray strobes at 3 and 10 must be ignored (R9)
                fetch_stb = (n == 3) || (n == 10) || (n == 66) ||
                            (n >= 71 && n <= 203 && ((n - 71) % 4) == 0) || (n == 207);
                load_stb  = (n == 60);
                load_val  = 7'h5D;
                busy = (n <= 13);
                if (load_stb)                exp_cnt = 7'h5D;
                else if (fetch_stb && !busy) exp_cnt = exp_cnt + 7'd1;
                step();
            end
        end
        idle_inputs();
        repeat (20) step();
        chk(ack_busy == 0 && svc_start == 0, "R8 back to run", ack_busy, 0);
    endtask

    initial begin
        t_reset();
        t_count_load();
        t_mask();
        t_lines(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule